// File: doc/BRIEF.md
# Balanced Ternary Ripple Adder

This block adds two signed numbers written in balanced ternary, where every digit (trit) is -1, 0 or +1, together with an incoming carry trit. It returns a sum word of the same width and an outgoing carry trit. Each trit travels on two binary wires. The arithmetic is a chain of identical one-trit full adders. Every stage is built from ternary primitives written as functions: the two ternary inverters, the value detectors, the cycling gates and a three-way selector. The stages do no binary XOR or AND arithmetic.

Operands arrive on a valid/ready stream, and the result leaves on a second valid/ready stream through a single output register. A word is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result is presented on the next cycle. The result stays on the outputs until the consumer raises `out_ready`. While the result waits, `in_ready` is low, so back-pressure reaches the producer within the same cycle. A new word may be accepted on the same edge that hands over the previous result.

Top module: `bal_tern_adder`

## Requirements
- R1: Every trit uses the encoding 2'b10 = -1, 2'b00 = 0 and 2'b01 = +1. The outputs `sum_trits` and `cout_trit` never carry the code 2'b11.
- R2: Trit i of a word (bits 2i+1:2i) has weight 3^i. For every accepted word, value(sum) + 3^N_TRITS * cout equals value(a) + value(b) + cin. With N_TRITS = 5, the multiplier is 243.
- R3: At the range limits the carry saturates correctly. All-(+1) operands with cin = +1 give sum 0 and cout +1. All-(-1) operands with cin = -1 give sum 0 and cout -1.
- R4: A carry ripples through every stage. a = all +1, b = 0 and cin = +1 give every sum trit equal to -1 and cout = +1.
- R5: The code 2'b11 on any input trit, or on `cin_trit`, counts as 0.
- R6: After a word is accepted, `out_valid` is high on the next cycle and carries that word's result.
- R7: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_valid`, `sum_trits` and `cout_trit` hold their values.
- R8: After reset, `out_valid` is low and `in_ready` is high.
- R9: If a result is taken (`out_valid` and `out_ready` both high) and no word is accepted on that edge, `out_valid` is low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand word offered |
| in_ready | output | 1 | Block can accept an operand word |
| a_trits | input | 2*N_TRITS | Operand A, trit i at bits 2i+1:2i |
| b_trits | input | 2*N_TRITS | Operand B, same layout |
| cin_trit | input | 2 | Carry-in trit |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| sum_trits | output | 2*N_TRITS | Sum word |
| cout_trit | output | 2 | Carry-out trit |

## Verification
A result is due exactly one rising edge after its operands are accepted. The bench drives inputs on the falling edge and reads the outputs on the falling edge that follows the accepting rising edge. It recomputes the expected value with plain integer arithmetic, independently of the design. In stall scenarios, the bench holds `out_ready` low for several cycles and confirms that the outputs stay unchanged and that `in_ready` stays low. It then releases the stall and reads the next result one edge later.

// File: rtl/tern_pkg.sv
package tern_pkg;
  typedef logic [1:0] trit_t;
  localparam trit_t TN = 2'b10;
  localparam trit_t TZ = 2'b00;
  localparam trit_t TP = 2'b01;

  // collapse the unused code onto zero
  function automatic trit_t t_norm(input trit_t x);
    return (x == TP || x == TN) ? x : TZ;
  endfunction

  function automatic trit_t t_neg(input trit_t x);
    case (t_norm(x))
      TP:      return TN;
      TN:      return TP;
      default: return TZ;
    endcase
  endfunction

  // positive inverter: 0 -> +1, else negate
  function automatic trit_t t_pti(input trit_t x);
    return (t_norm(x) == TZ) ? TP : t_neg(x);
  endfunction

  // negative inverter: 0 -> -1, else negate
  function automatic trit_t t_nti(input trit_t x);
    return (t_norm(x) == TZ) ? TN : t_neg(x);
  endfunction

  function automatic trit_t t_min(input trit_t x, input trit_t y);
    trit_t xn, yn;
    xn = t_norm(x);
    yn = t_norm(y);
    if (xn == TN || yn == TN) return TN;
    if (xn == TZ || yn == TZ) return TZ;
    return TP;
  endfunction

  // value detectors: +1 when the input equals the level, -1 otherwise
  function automatic trit_t lit_n(input trit_t x);
    return t_nti(x);
  endfunction

  function automatic trit_t lit_p(input trit_t x);
    return t_nti(t_pti(x));
  endfunction

  function automatic trit_t lit_z(input trit_t x);
    return t_min(t_neg(lit_n(x)), t_neg(lit_p(x)));
  endfunction

  // cycling gates over residues (-1,0,+1) -> (0,1,2)
  function automatic trit_t t_cyc(input trit_t x);
    case (t_norm(x))
      TN:      return TZ;
      TZ:      return TP;
      default: return TN;
    endcase
  endfunction

  function automatic trit_t t_icyc(input trit_t x);
    case (t_norm(x))
      TN:      return TP;
      TZ:      return TN;
      default: return TZ;
    endcase
  endfunction

  // earthed detectors: level itself when matched, zero otherwise
  function automatic trit_t t_ehi(input trit_t x);
    return (lit_p(x) == TP) ? TP : TZ;
  endfunction

  function automatic trit_t t_elo(input trit_t x);
    return (lit_n(x) == TP) ? TN : TZ;
  endfunction

  // three-way selector steered by a trit
  function automatic trit_t t_gate(input trit_t sel, input trit_t on_n,
                                   input trit_t on_z, input trit_t on_p);
    if (lit_n(sel) == TP) return on_n;
    if (lit_z(sel) == TP) return on_z;
    return on_p;
  endfunction
endpackage

// File: rtl/tern_fa.sv
module tern_fa
  import tern_pkg::*;
(
  input  trit_t a_i,
  input  trit_t b_i,
  input  trit_t c_i,
  output trit_t s_o,
  output trit_t c_o
);
  trit_t an, bn, cn, part, c_ab, c_pc;

  always_comb begin
    an   = t_norm(a_i);
    bn   = t_norm(b_i);
    cn   = t_norm(c_i);
    // sum section: rotate a by b, then rotate by carry-in
    part = t_gate(bn, t_icyc(an), an, t_cyc(an));
    s_o  = t_gate(cn, t_icyc(part), part, t_cyc(part));
    // carry section: two partial carries merged by a third selector
    c_ab = t_gate(bn, t_elo(an), TZ, t_ehi(an));
    c_pc = t_gate(cn, t_elo(part), TZ, t_ehi(part));
    c_o  = t_gate(c_ab, t_icyc(c_pc), c_pc, t_cyc(c_pc));
  end
endmodule

// File: rtl/tern_chain.sv
module tern_chain
  import tern_pkg::*;
#(
  parameter int N_TRITS = 5
) (
  input  logic [2*N_TRITS-1:0] a_w,
  input  logic [2*N_TRITS-1:0] b_w,
  input  trit_t                cin,
  output logic [2*N_TRITS-1:0] s_w,
  output trit_t                cout
);
  trit_t cy [N_TRITS+1];

  assign cy[0] = cin;

  for (genvar g = 0; g < N_TRITS; g++) begin : g_stage
    tern_fa u_fa (
      .a_i (a_w[2*g +: 2]),
      .b_i (b_w[2*g +: 2]),
      .c_i (cy[g]),
      .s_o (s_w[2*g +: 2]),
      .c_o (cy[g+1])
    );
  end

  assign cout = cy[N_TRITS];
endmodule

// File: rtl/bal_tern_adder.sv
module bal_tern_adder
  import tern_pkg::*;
#(
  parameter int N_TRITS = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [2*N_TRITS-1:0] a_trits,
  input  logic [2*N_TRITS-1:0] b_trits,
  input  logic [1:0]           cin_trit,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [2*N_TRITS-1:0] sum_trits,
  output logic [1:0]           cout_trit
);
  localparam int W = 2 * N_TRITS;

  logic [W-1:0] s_comb;
  trit_t        c_comb;
  logic         take;

  tern_chain #(.N_TRITS(N_TRITS)) u_chain (
    .a_w  (a_trits),
    .b_w  (b_trits),
    .cin  (cin_trit),
    .s_w  (s_comb),
    .cout (c_comb)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      sum_trits <= '0;
      cout_trit <= TZ;
    end else begin
      if (take) begin
        sum_trits <= s_comb;
        cout_trit <= c_comb;
      end
      if (take) out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/bal_tern_adder_chk.sv
module bal_tern_adder_chk #(
  parameter int N_TRITS = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [2*N_TRITS-1:0] a_trits,
  input logic [2*N_TRITS-1:0] b_trits,
  input logic [1:0]           cin_trit,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [2*N_TRITS-1:0] sum_trits,
  input logic [1:0]           cout_trit
);
  function automatic longint dig(input logic [1:0] t);
    return (t == 2'b01) ? 64'sd1 : (t == 2'b10) ? -64'sd1 : 64'sd0;
  endfunction

  function automatic longint wval(input logic [2*N_TRITS-1:0] w);
    longint acc = 0;
    for (int i = N_TRITS - 1; i >= 0; i--) acc = acc * 3 + dig(w[2*i +: 2]);
    return acc;
  endfunction

  function automatic longint p3();
    longint r = 1;
    for (int i = 0; i < N_TRITS; i++) r = r * 3;
    return r;
  endfunction

  logic out_bad;
  always_comb begin
    out_bad = (cout_trit == 2'b11);
    for (int i = 0; i < N_TRITS; i++)
      if (sum_trits[2*i +: 2] == 2'b11) out_bad = 1'b1;
  end

  AST_LEGAL_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    !out_bad); // R1

  AST_SUM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=>
      (wval(sum_trits) + p3() * dig(cout_trit) ==
       $past(wval(a_trits) + wval(b_trits) + dig(cin_trit)))); // R2

  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R6

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(sum_trits) && $stable(cout_trit))); // R7

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R7

  AST_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid); // R9
endmodule

bind bal_tern_adder bal_tern_adder_chk #(.N_TRITS(N_TRITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .a_trits   (a_trits),
  .b_trits   (b_trits),
  .cin_trit  (cin_trit),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .sum_trits (sum_trits),
  .cout_trit (cout_trit)
);

// File: tb/bal_tern_adder_test.sv
module bal_tern_adder_test;
  localparam int N = 5;
  localparam int W = 2 * N;
  localparam int P3 = 243;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] a_trits = '0;
  logic [W-1:0] b_trits = '0;
  logic [1:0]   cin_trit = 2'b00;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] sum_trits;
  logic [1:0]   cout_trit;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bal_tern_adder #(.N_TRITS(N)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .a_trits(a_trits), .b_trits(b_trits), .cin_trit(cin_trit),
    .out_valid(out_valid), .out_ready(out_ready),
    .sum_trits(sum_trits), .cout_trit(cout_trit)
  );

  function automatic logic [W-1:0] enc(input int v);
    logic [W-1:0] w = '0;
    int r;
    for (int i = 0; i < N; i++) begin
      r = v % 3;
      if (r < 0) r += 3;
      if (r == 1) begin w[2*i +: 2] = 2'b01; v = (v - 1) / 3; end
      else if (r == 2) begin w[2*i +: 2] = 2'b10; v = (v + 1) / 3; end
      else v = v / 3;
    end
    return w;
  endfunction

  function automatic int d1(input logic [1:0] t);
    return (t == 2'b01) ? 1 : (t == 2'b10) ? -1 : 0;
  endfunction

  function automatic int dec(input logic [W-1:0] w);
    int acc = 0;
    for (int i = N - 1; i >= 0; i--) acc = acc * 3 + d1(w[2*i +: 2]);
    return acc;
  endfunction

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_legal();
    bit ok = (cout_trit != 2'b11);
    for (int i = 0; i < N; i++) if (sum_trits[2*i +: 2] == 2'b11) ok = 1'b0;
    chk("R1 legal output codes", ok, int'(sum_trits), 0);
  endtask

  // drive one word at a falling edge, read its result one rising edge later
  task automatic send(input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic [1:0] c, input int exp);
    @(negedge clk);
    a_trits = a; b_trits = b; cin_trit = c; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R6 result valid one cycle after accept", out_valid, out_valid, 1);
    chk_legal();
    chk("R2 value(S)+243*cout", dec(sum_trits) + P3 * d1(cout_trit) == exp,
        dec(sum_trits) + P3 * d1(cout_trit), exp);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R8 out_valid low after reset", !out_valid, out_valid, 0);
    chk("R8 in_ready high after reset", in_ready, in_ready, 1);
  endtask

  task automatic t_limits();
    send(enc(121), enc(121), 2'b01, 243);
    chk("R3 max sum zero", sum_trits == '0, dec(sum_trits), 0);
    chk("R3 max carry +1", cout_trit == 2'b01, d1(cout_trit), 1);
    send(enc(-121), enc(-121), 2'b10, -243);
    chk("R3 min sum zero", sum_trits == '0, dec(sum_trits), 0);
    chk("R3 min carry -1", cout_trit == 2'b10, d1(cout_trit), -1);
    send('0, '0, 2'b00, 0);
    chk("R2 zero operands", sum_trits == '0 && cout_trit == 2'b00, dec(sum_trits), 0);
  endtask

  task automatic t_ripple();
    send(enc(121), '0, 2'b01, 122);
    chk("R4 ripple: every sum trit -1", sum_trits == {N{2'b10}}, dec(sum_trits), -121);
    chk("R4 ripple: carry +1", cout_trit == 2'b01, d1(cout_trit), 1);
    send(enc(-121), '0, 2'b10, -122);
    chk("R4 ripple: every sum trit +1", sum_trits == {N{2'b01}}, dec(sum_trits), 121);
  endtask

  task automatic t_single_stage();
    for (int x = -1; x <= 1; x++)
      for (int y = -1; y <= 1; y++)
        for (int z = -1; z <= 1; z++)
          send(enc(x), enc(y), enc(z)[1:0], x + y + z);
  endtask

  task automatic t_random();
    for (int k = 0; k < 1500; k++) begin
      int x = int'($urandom_range(0, 242)) - 121;
      int y = int'($urandom_range(0, 242)) - 121;
      int z = int'($urandom_range(0, 2)) - 1;
      send(enc(x), enc(y), enc(z)[1:0], x + y + z);
    end
  endtask

  task automatic t_illegal();
    logic [W-1:0] a = enc(1);
    a[5:4] = 2'b11;
    send(a, enc(13), 2'b11, 14);
    chk("R5 code 11 counts as zero", dec(sum_trits) == 14 && cout_trit == 2'b00,
        dec(sum_trits), 14);
  endtask

  task automatic t_stall();
    logic [W-1:0] held;
    @(negedge clk);
    a_trits = enc(40); b_trits = enc(-7); cin_trit = 2'b01; in_valid = 1'b1;
    out_ready = 1'b0;
    @(negedge clk);
    held = sum_trits;
    a_trits = enc(-50); b_trits = enc(20); cin_trit = 2'b10;
    chk("R6 stalled result value", dec(sum_trits) == 34, dec(sum_trits), 34);
    repeat (3) @(negedge clk);
    chk("R7 in_ready low while stalled", !in_ready, in_ready, 0);
    chk("R7 out_valid held", out_valid, out_valid, 1);
    chk("R7 sum held", sum_trits == held, dec(sum_trits), dec(held));
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7 next word taken on release", out_valid && dec(sum_trits) == -31,
        dec(sum_trits), -31);
    @(negedge clk);
    chk("R9 out_valid drops after drain", !out_valid, out_valid, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_limits();
    t_ripple();
    t_single_stage();
    t_illegal();
    t_stall();
    t_random();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule